// File: doc/BRIEF.md
# Sleep Command Control Register

This block holds one 16-bit power management control word and turns software writes into power state requests. A write stores the word, apart from a single strobe bit. When that strobe is written as one, the 3-bit sleep type carried in the same write is decoded into a one-cycle request pulse: power off, suspend to RAM, or hibernate. A hibernate request is always followed on the next cycle by a power-off pulse. The type value that means hibernate is supplied at run time on an input, so one build serves platforms that assign it differently.

Bit 0 of the word is an interrupt-enable flag that two side inputs can force: a set input and a clear input, with set winning. Reads return the stored word at all times. The power sequencing that acts on the requests sits outside this block.

Top module: `pmctl_sleep_reg`

## Requirements
- R1: A write (`wr_en` high at a rising clock edge) stores `wr_data` with bit 13 (the sleep strobe) forced to zero; `rd_data` shows the stored word from the cycle after that edge, and the word holds its value when neither a write nor a force input is active.
- R2: After reset the stored word is 0x0000 and no request output is high.
- R3: A write with bit 13 at zero issues no request, whatever the type field holds.
- R4: A write with bit 13 set and type field bits 12:10 equal to 0 pulses `req_poweroff` high for exactly the cycle after the write edge.
- R5: A write with bit 13 set and type 1 pulses `req_suspend` high for exactly the cycle after the write edge.
- R6: A write with bit 13 set and a type other than 0 or 1 that equals `hib_code` pulses `req_hibernate` in the cycle after the write edge and then `req_poweroff` in the cycle after that.
- R7: A write with bit 13 set and a type that is neither 0, 1 nor `hib_code` issues no request.
- R8: Types 0 and 1 keep their meaning when `hib_code` is 0 or 1: no hibernate pulse and no trailing power-off pulse.
- R9: `ien_set` high at an edge leaves bit 0 of the word at one, taking priority over `ien_clr` and over a write in the same cycle.
- R10: `ien_clr` high with `ien_set` low at an edge leaves bit 0 at zero, taking priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Word written; bit 13 sleep strobe, bits 12:10 sleep type, bit 0 interrupt enable |
| hib_code | input | 3 | Sleep type value that selects hibernate |
| ien_set | input | 1 | Forces the interrupt-enable bit to one |
| ien_clr | input | 1 | Forces the interrupt-enable bit to zero when set is low |
| rd_data | output | 16 | Stored control word |
| req_poweroff | output | 1 | Power-off request pulse |
| req_suspend | output | 1 | Suspend-to-RAM request pulse |
| req_hibernate | output | 1 | Hibernate request pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit word, strobe at bit 13, type at bits 12:10 and the enable flag at bit 0. Because the hibernate code is an input, those defaults still reach every decode path: the bench moves `hib_code` between 5, 1 and 0 to cover a normal hibernate match, an unmatched type, and hibernate codes that collide with the fixed power-off and suspend types. The force inputs are exercised alone, together, and against a same-cycle write to confirm their priority.

// File: rtl/pmctl_pkg.sv
package pmctl_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_OFF  = 2'd1,
      CMD_SUSP = 2'd2,
      CMD_HIB  = 2'd3
   } sleep_cmd_e;

   localparam int NUM_REQ  = 3;
   localparam int REQ_OFF  = 0;
   localparam int REQ_SUSP = 1;
   localparam int REQ_HIB  = 2;

   function automatic sleep_cmd_e slot_cmd(input int idx);
      case (idx)
         REQ_OFF:  return CMD_OFF;
         REQ_SUSP: return CMD_SUSP;
         default:  return CMD_HIB;
      endcase
   endfunction

endpackage

// File: rtl/pmctl_ctl_store.sv
module pmctl_ctl_store #(
   parameter int DATA_W  = 16,
   parameter int SLP_BIT = 13,
   parameter int IEN_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ien_set,
   input  logic              ien_clr,
   output logic [DATA_W-1:0] word_q
);

   localparam logic [DATA_W-1:0] SLP_MASK = DATA_W'(1) << SLP_BIT;
   localparam logic [DATA_W-1:0] IEN_MASK = DATA_W'(1) << IEN_BIT;

   logic [DATA_W-1:0] word_d;

   always_comb begin
      word_d = word_q;
      if (wr_en) begin
         word_d = wr_data & ~SLP_MASK;
      end
      if (ien_set) begin
         word_d = word_d | IEN_MASK;
      end else if (ien_clr) begin
         word_d = word_d & ~IEN_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else begin
         word_q <= word_d;
      end
   end

endmodule

// File: rtl/pmctl_sleep_decode.sv
module pmctl_sleep_decode
   import pmctl_pkg::*;
#(
   parameter int TYPE_W = 3
) (
   input  logic              strobe,
   input  logic [TYPE_W-1:0] slp_type,
   input  logic [TYPE_W-1:0] hib_code,
   output sleep_cmd_e        cmd
);

   localparam logic [TYPE_W-1:0] TYPE_OFF  = TYPE_W'(0);
   localparam logic [TYPE_W-1:0] TYPE_SUSP = TYPE_W'(1);

   always_comb begin
      cmd = CMD_NONE;
      if (strobe) begin
         if (slp_type == TYPE_OFF) begin
            cmd = CMD_OFF;
         end else if (slp_type == TYPE_SUSP) begin
            cmd = CMD_SUSP;
         end else if (slp_type == hib_code) begin
            cmd = CMD_HIB;
         end
      end
   end

endmodule

// File: rtl/pmctl_req_pulse.sv
module pmctl_req_pulse
   import pmctl_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  sleep_cmd_e         cmd,
   output logic [NUM_REQ-1:0] req_q,
   output logic               tail_off_q
);

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q[i] <= 1'b0;
         end else begin
            req_q[i] <= (cmd == slot_cmd(i));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_off_q <= 1'b0;
      end else begin
         tail_off_q <= req_q[REQ_HIB];
      end
   end

endmodule

// File: rtl/pmctl_sleep_reg.sv
module pmctl_sleep_reg
   import pmctl_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int SLP_BIT  = 13,
   parameter int TYPE_LSB = 10,
   parameter int TYPE_W   = 3,
   parameter int IEN_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TYPE_W-1:0] hib_code,
   input  logic              ien_set,
   input  logic              ien_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              req_poweroff,
   output logic              req_suspend,
   output logic              req_hibernate
);

   localparam int TYPE_MSB = TYPE_LSB + TYPE_W - 1;

   if (TYPE_W < 2) begin : g_bad_type_w
      $error("TYPE_W must hold at least the codes 0..2");
   end
   if (TYPE_MSB >= DATA_W || SLP_BIT >= DATA_W || IEN_BIT >= DATA_W) begin : g_bad_range
      $error("field positions exceed DATA_W");
   end
   if (SLP_BIT >= TYPE_LSB && SLP_BIT <= TYPE_MSB) begin : g_bad_slp
      $error("strobe bit overlaps the type field");
   end
   if (IEN_BIT == SLP_BIT || (IEN_BIT >= TYPE_LSB && IEN_BIT <= TYPE_MSB)) begin : g_bad_ien
      $error("enable bit overlaps another field");
   end

   sleep_cmd_e         cmd;
   logic [NUM_REQ-1:0] req_q;
   logic               tail_off_q;

   pmctl_ctl_store #(
      .DATA_W  (DATA_W),
      .SLP_BIT (SLP_BIT),
      .IEN_BIT (IEN_BIT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ien_set (ien_set),
      .ien_clr (ien_clr),
      .word_q  (rd_data)
   );

   pmctl_sleep_decode #(
      .TYPE_W (TYPE_W)
   ) u_decode (
      .strobe   (wr_en & wr_data[SLP_BIT]),
      .slp_type (wr_data[TYPE_MSB:TYPE_LSB]),
      .hib_code (hib_code),
      .cmd      (cmd)
   );

   pmctl_req_pulse u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .req_q      (req_q),
      .tail_off_q (tail_off_q)
   );

   assign req_poweroff  = req_q[REQ_OFF] | tail_off_q;
   assign req_suspend   = req_q[REQ_SUSP];
   assign req_hibernate = req_q[REQ_HIB];

endmodule

// File: rtl/pmctl_sleep_reg_chk.sv
module pmctl_sleep_reg_chk #(
   parameter int DATA_W   = 16,
   parameter int SLP_BIT  = 13,
   parameter int TYPE_LSB = 10,
   parameter int TYPE_W   = 3,
   parameter int IEN_BIT  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [TYPE_W-1:0] hib_code,
   input logic              ien_set,
   input logic              ien_clr,
   input logic [DATA_W-1:0] rd_data,
   input logic              req_poweroff,
   input logic              req_suspend,
   input logic              req_hibernate
);

   assert_strobe_unstored_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[SLP_BIT]);

   assert_word_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !ien_set && !ien_clr) |=> $stable(rd_data));

   assert_quiet_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[SLP_BIT]) |=> (!req_suspend && !req_hibernate));

   assert_suspend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_suspend |-> $past(wr_en && wr_data[SLP_BIT]
                            && wr_data[TYPE_LSB +: TYPE_W] == TYPE_W'(1)));

   assert_hib_then_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_hibernate |=> req_poweroff);

   assert_ien_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ien_set |=> rd_data[IEN_BIT]);

   assert_ien_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_clr && !ien_set) |=> !rd_data[IEN_BIT]);

endmodule

bind pmctl_sleep_reg pmctl_sleep_reg_chk #(
   .DATA_W   (DATA_W),
   .SLP_BIT  (SLP_BIT),
   .TYPE_LSB (TYPE_LSB),
   .TYPE_W   (TYPE_W),
   .IEN_BIT  (IEN_BIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .hib_code      (hib_code),
   .ien_set       (ien_set),
   .ien_clr       (ien_clr),
   .rd_data       (rd_data),
   .req_poweroff  (req_poweroff),
   .req_suspend   (req_suspend),
   .req_hibernate (req_hibernate)
);

// File: tb/pmctl_sleep_reg_tb.sv
module pmctl_sleep_reg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [2:0]  hib_code = 3'd5;
   logic        ien_set = 1'b0;
   logic        ien_clr = 1'b0;
   logic [15:0] rd_data;
   logic        req_poweroff, req_suspend, req_hibernate;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pmctl_sleep_reg u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .hib_code      (hib_code),
      .ien_set       (ien_set),
      .ien_clr       (ien_clr),
      .rd_data       (rd_data),
      .req_poweroff  (req_poweroff),
      .req_suspend   (req_suspend),
      .req_hibernate (req_hibernate)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] reqs();
      return {13'd0, req_hibernate, req_suspend, req_poweroff};
   endfunction

   // Write one word; check pulses {hib,susp,off} for the two cycles after the edge.
   task automatic do_write(input string req, input logic [15:0] d,
                           input logic [15:0] exp_rd,
                           input logic [2:0] exp1, input logic [2:0] exp2);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
      chk(req, reqs(), {13'd0, exp1});
      chk(req, rd_data, exp_rd);
      @(negedge clk);
      chk(req, reqs(), {13'd0, exp2});
      @(negedge clk);
      chk(req, reqs(), 16'd0);
   endtask

   task automatic force_ien(input string req, input logic s, input logic c,
                            input logic w, input logic [15:0] d,
                            input logic [15:0] exp_rd);
      @(negedge clk);
      ien_set = s;
      ien_clr = c;
      wr_en = w;
      wr_data = d;
      @(negedge clk);
      ien_set = 1'b0;
      ien_clr = 1'b0;
      wr_en = 1'b0;
      wr_data = '0;
      chk(req, rd_data, exp_rd);
   endtask

   task automatic t_reset();
      chk("R2", rd_data, 16'h0000);
      chk("R2", reqs(), 16'd0);
   endtask

   task automatic t_store_no_strobe();
      do_write("R1", 16'h1401, 16'h1401, 3'b000, 3'b000);
      do_write("R3", 16'h0000, 16'h0000, 3'b000, 3'b000);
      do_write("R3", 16'h1c00, 16'h1c00, 3'b000, 3'b000);
      repeat (3) @(negedge clk);
      chk("R1", rd_data, 16'h1c00);
   endtask

   task automatic t_poweroff();
      do_write("R4", 16'h2000, 16'h0000, 3'b001, 3'b000);
   endtask

   task automatic t_suspend();
      do_write("R5", 16'h2400, 16'h0400, 3'b010, 3'b000);
   endtask

   task automatic t_hibernate();
      hib_code = 3'd5;
      do_write("R6", 16'h3400, 16'h1400, 3'b100, 3'b001);
      hib_code = 3'd7;
      do_write("R6", 16'hfc00, 16'hdc00, 3'b100, 3'b001);
   endtask

   task automatic t_unmatched();
      hib_code = 3'd5;
      do_write("R7", 16'h3800, 16'h1800, 3'b000, 3'b000);
      do_write("R7", 16'h2800, 16'h0800, 3'b000, 3'b000);
   endtask

   task automatic t_hib_collide();
      hib_code = 3'd1;
      do_write("R8", 16'h2400, 16'h0400, 3'b010, 3'b000);
      hib_code = 3'd0;
      do_write("R8", 16'h2000, 16'h0000, 3'b001, 3'b000);
      hib_code = 3'd5;
   endtask

   task automatic t_ien();
      do_write("R1", 16'h1400, 16'h1400, 3'b000, 3'b000);
      force_ien("R9", 1'b1, 1'b0, 1'b0, 16'h0000, 16'h1401);
      force_ien("R10", 1'b0, 1'b1, 1'b0, 16'h0000, 16'h1400);
      force_ien("R9", 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1401);
      force_ien("R9", 1'b1, 1'b0, 1'b1, 16'h0000, 16'h0001);
      force_ien("R10", 1'b0, 1'b1, 1'b1, 16'h0201, 16'h0200);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_store_no_strobe();
      t_poweroff();
      t_suspend();
      t_hibernate();
      t_unmatched();
      t_hib_collide();
      t_ien();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule